// File: doc/BRIEF.md
# Shadowed Counter Compare Unit

This block is the counter-compare stage of a PWM channel. Software places a 16-bit compare value and an 8-bit high-resolution extension into the block over a simple register bus. Every cycle the block compares the live 16-bit value with an external time-base counter. When the two become equal, it raises a one-cycle event for the downstream action logic. The live value and the high-resolution byte are also brought out, so a fine-delay stage can use them.

Each value can be double-buffered. In buffered mode, software writes a hidden shadow copy. The live copy picks up the shadow only on a time-base event selected in the control word: counter at zero, counter at period, either of them, or never. In direct mode, writes change the live copy at once. Both copies sit behind one bus address, and the mode decides which copy a read or a write reaches. The high-resolution byte is reachable at a primary address and at a write-only alias. A combined 32-bit address carries both fields in one access.

Top module: `shadowed_compare_unit`

## Requirements
- R1: `cmp_evt` is high for exactly one cycle. It rises in the cycle after the first cycle in which `tb_ctr` equals `cmp_active`. A counter that stays equal over several cycles gives only one pulse, and a new pulse needs a non-matching cycle in between.
- R2: When control bit 0 is 0, writes and reads at the compare, high-resolution, mirror and combined addresses reach the shadow copies. `cmp_active` and `hr_active` do not change until a load happens.
- R3: When control bit 0 is 1, a write updates `cmp_active` or `hr_active` at the next clock edge, and reads return the live values. Load strobes then have no effect, and the shadow copies keep their contents.
- R4: Control bits 2:1 choose the load event: 00 loads on `ctr_zero`, 01 on `ctr_prd`, 10 on either, and 11 never loads. The shadow-to-live copy happens at the clock edge that ends the cycle in which the selected strobe is high.
- R5: The comparison in the cycle of a load strobe uses the live value from before the load.
- R6: If a shadow write and a load fall in the same cycle, the live copy takes the old shadow value and the shadow copy takes the written data.
- R7: At address 2, the high-resolution byte sits in bits 15:8. Bits 7:0 and 31:16 read as 0, and writes to them are dropped.
- R8: Address 3 accepts writes exactly as address 2 does and always reads as 0.
- R9: Address 4 holds the compare value in bits 31:16 and the high-resolution byte in bits 15:8, with bits 7:0 reading as 0. It follows the same shadow rules as the separate addresses.
- R10: After reset, the live and shadow values are 0, control bit 0 is 0, the load select is 00 and `cmp_evt` is low.
- R11: Address 0 holds the control word, which reads as {0, load select[1:0], shadow-off}. Address 1 holds the compare value in bits 15:0. Addresses 5 to 7 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tb_ctr | input | 16 | Time-base counter value |
| ctr_zero | input | 1 | Counter-at-zero strobe |
| ctr_prd | input | 1 | Counter-at-period strobe |
| cmp_active | output | 16 | Live compare value |
| hr_active | output | 8 | Live high-resolution byte |
| cmp_evt | output | 1 | Counter-equals-compare event |

## Verification
The assertions assume that `ctr_zero` and `ctr_prd` stay low while reset is held. Under that assumption, no load attempt can start in a reset cycle and end in the first cycle after it. The bench drives both strobes low during reset and changes every input only on falling edges. It then sweeps all load selects against all strobe combinations, and sweeps the counter across 64 values for several compare settings, including a stalled counter.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

   // Load-event selector held in control bits 2:1
   typedef enum logic [1:0] {
      LD_ZERO   = 2'b00,
      LD_PRD    = 2'b01,
      LD_BOTH   = 2'b10,
      LD_FREEZE = 2'b11
   } cmpu_ldmode_e;

   // Register map (word addresses)
   localparam int unsigned CMPU_A_CTRL = 0;
   localparam int unsigned CMPU_A_CMP  = 1;
   localparam int unsigned CMPU_A_HR   = 2;
   localparam int unsigned CMPU_A_MIR  = 3;
   localparam int unsigned CMPU_A_BOTH = 4;

   localparam int unsigned CMPU_CTRL_W = 3;

   function automatic logic cmpu_load_hit(input cmpu_ldmode_e m,
                                          input logic at_zero,
                                          input logic at_prd);
      logic hit;
      case (m)
         LD_ZERO: hit = at_zero;
         LD_PRD:  hit = at_prd;
         LD_BOTH: hit = at_zero | at_prd;
         default: hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/cmpu_ctrl.sv
module cmpu_ctrl
   import cmpu_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ctrl_wr,
   input  logic [CMPU_CTRL_W-1:0] ctrl_wdata,
   input  logic                   ctr_zero,
   input  logic                   ctr_prd,
   output logic                   shd_off,
   output cmpu_ldmode_e           ld_mode,
   output logic                   load_go
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_off <= 1'b0;
         ld_mode <= LD_ZERO;
      end else if (ctrl_wr) begin
         shd_off <= ctrl_wdata[0];
         ld_mode <= cmpu_ldmode_e'(ctrl_wdata[2:1]);
      end
   end

   // Transfers only happen while buffering is in force
   always_comb begin
      load_go = !shd_off && cmpu_load_hit(ld_mode, ctr_zero, ctr_prd);
   end

endmodule

// File: rtl/cmpu_regslot.sv
module cmpu_regslot #(
   parameter int unsigned W          = 16,
   parameter bit          HAS_SHADOW = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic         direct,
   input  logic         load_go,
   output logic [W-1:0] active,
   output logic [W-1:0] shadow,
   output logic [W-1:0] rd_val
);

   generate
      if (HAS_SHADOW) begin : g_buffered
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shadow <= '0;
            end else if (wr_en && !direct) begin
               shadow <= wdata;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               active <= '0;
            end else if (wr_en && direct) begin
               active <= wdata;
            end else if (load_go) begin
               active <= shadow;
            end
         end

         always_comb begin
            rd_val = direct ? active : shadow;
         end
      end else begin : g_direct_only
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               active <= '0;
            end else if (wr_en) begin
               active <= wdata;
            end
         end

         always_comb begin
            shadow = active;
            rd_val = active;
         end
      end
   endgenerate

endmodule

// File: rtl/cmpu_match.sv
module cmpu_match #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ctr,
   input  logic [W-1:0] ref_val,
   output logic         evt
);

   logic hit, hit_q;

   always_comb begin
      hit = (ctr == ref_val);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         evt   <= 1'b0;
      end else begin
         hit_q <= hit;
         evt   <= hit && !hit_q;
      end
   end

endmodule

// File: rtl/shadowed_compare_unit.sv
module shadowed_compare_unit
   import cmpu_pkg::*;
#(
   parameter int unsigned CMP_W      = 16,
   parameter int unsigned HR_W       = 8,
   parameter int unsigned BUS_W      = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter bit          HAS_SHADOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [CMP_W-1:0]  tb_ctr,
   input  logic              ctr_zero,
   input  logic              ctr_prd,
   output logic [CMP_W-1:0]  cmp_active,
   output logic [HR_W-1:0]   hr_active,
   output logic              cmp_evt
);

   localparam int unsigned LOW_PAD  = CMP_W - HR_W;
   localparam int unsigned HIGH_PAD = BUS_W - CMP_W;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CMPU_A_CTRL);
   localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CMPU_A_CMP);
   localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(CMPU_A_HR);
   localparam logic [ADDR_W-1:0] A_MIR  = ADDR_W'(CMPU_A_MIR);
   localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(CMPU_A_BOTH);

   generate
      if (BUS_W != 2 * CMP_W) begin : g_bad_bus
         $error("BUS_W must be twice CMP_W for the combined access");
      end
      if (HR_W == 0 || HR_W >= CMP_W) begin : g_bad_hr
         $error("HR_W must lie between 1 and CMP_W-1");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover five register addresses");
      end
   endgenerate

   // Decode
   logic ctrl_wr, cmp_wr, hr_wr;
   logic [CMP_W-1:0] cmp_wdata;
   logic [HR_W-1:0]  hr_wdata;

   always_comb begin
      ctrl_wr   = bus_wen && (bus_addr == A_CTRL);
      cmp_wr    = bus_wen && (bus_addr == A_CMP || bus_addr == A_BOTH);
      hr_wr     = bus_wen && (bus_addr == A_HR || bus_addr == A_MIR ||
                              bus_addr == A_BOTH);
      cmp_wdata = (bus_addr == A_BOTH) ? bus_wdata[BUS_W-1 -: CMP_W]
                                       : bus_wdata[CMP_W-1:0];
      hr_wdata  = bus_wdata[CMP_W-1 -: HR_W];
   end

   // Control
   logic         shd_off;
   logic         load_go;
   cmpu_ldmode_e ld_mode;

   cmpu_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (ctrl_wr),
      .ctrl_wdata (bus_wdata[CMPU_CTRL_W-1:0]),
      .ctr_zero   (ctr_zero),
      .ctr_prd    (ctr_prd),
      .shd_off    (shd_off),
      .ld_mode    (ld_mode),
      .load_go    (load_go)
   );

   // Storage
   logic [CMP_W-1:0] cmp_shadow, cmp_rd;
   logic [HR_W-1:0]  hr_shadow, hr_rd;

   cmpu_regslot #(.W(CMP_W), .HAS_SHADOW(HAS_SHADOW)) u_cmp_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmp_wr),
      .wdata   (cmp_wdata),
      .direct  (shd_off),
      .load_go (load_go),
      .active  (cmp_active),
      .shadow  (cmp_shadow),
      .rd_val  (cmp_rd)
   );

   cmpu_regslot #(.W(HR_W), .HAS_SHADOW(HAS_SHADOW)) u_hr_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hr_wr),
      .wdata   (hr_wdata),
      .direct  (shd_off),
      .load_go (load_go),
      .active  (hr_active),
      .shadow  (hr_shadow),
      .rd_val  (hr_rd)
   );

   // Equality event
   cmpu_match #(.W(CMP_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctr     (tb_ctr),
      .ref_val (cmp_active),
      .evt     (cmp_evt)
   );

   // Read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:  bus_rdata = {{(BUS_W-CMPU_CTRL_W){1'b0}}, ld_mode, shd_off};
         A_CMP:   bus_rdata = {{HIGH_PAD{1'b0}}, cmp_rd};
         A_HR:    bus_rdata = {{HIGH_PAD{1'b0}}, hr_rd, {LOW_PAD{1'b0}}};
         A_BOTH:  bus_rdata = {cmp_rd, hr_rd, {LOW_PAD{1'b0}}};
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cmpu_chk.sv
module cmpu_chk
   import cmpu_pkg::*;
#(
   parameter int unsigned CMP_W  = 16,
   parameter int unsigned HR_W   = 8,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [CMP_W-1:0]  tb_ctr,
   input logic [CMP_W-1:0]  cmp_active,
   input logic [HR_W-1:0]   hr_active,
   input logic              cmp_evt,
   input logic              load_go,
   input logic              cmp_wr,
   input logic              shd_off,
   input logic [CMP_W-1:0]  cmp_shadow,
   input logic [HR_W-1:0]   hr_shadow
);

   localparam int unsigned LOW_PAD = CMP_W - HR_W;
   localparam logic [ADDR_W-1:0] A_HR  = ADDR_W'(CMPU_A_HR);
   localparam logic [ADDR_W-1:0] A_MIR = ADDR_W'(CMPU_A_MIR);

   // R1
   evt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |-> $past(tb_ctr == cmp_active));

   // R1
   evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |=> !cmp_evt);

   // R2
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_go && !(cmp_wr && shd_off)) |=> $stable(cmp_active));

   // R4
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_go |=> (cmp_active == $past(cmp_shadow)));

   // R9
   hr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_go |=> (hr_active == $past(hr_shadow)));

   // R8
   mirror_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_MIR) |-> (bus_rdata == '0));

   // R7
   hr_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_HR) |-> (bus_rdata[LOW_PAD-1:0] == '0 &&
                              bus_rdata[BUS_W-1:CMP_W] == '0));

endmodule

bind shadowed_compare_unit cmpu_chk #(
   .CMP_W (CMP_W),
   .HR_W  (HR_W),
   .BUS_W (BUS_W),
   .ADDR_W(ADDR_W)
) i_cmpu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .tb_ctr     (tb_ctr),
   .cmp_active (cmp_active),
   .hr_active  (hr_active),
   .cmp_evt    (cmp_evt),
   .load_go    (load_go),
   .cmp_wr     (cmp_wr),
   .shd_off    (shd_off),
   .cmp_shadow (cmp_shadow),
   .hr_shadow  (hr_shadow)
);

// File: tb/test_shadowed_compare_unit.sv
module test_shadowed_compare_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] tb_ctr = 16'hFFFF;
   logic        ctr_zero = 1'b0;
   logic        ctr_prd = 1'b0;
   logic [15:0] cmp_active;
   logic [7:0]  hr_active;
   logic        cmp_evt;

   int errors = 0;
   int checks = 0;
   logic last_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shadowed_compare_unit i_shadowed_compare_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_ctr(tb_ctr),
      .ctr_zero(ctr_zero), .ctr_prd(ctr_prd), .cmp_active(cmp_active),
      .hr_active(hr_active), .cmp_evt(cmp_evt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic strobe(input logic z, input logic p);
      @(negedge clk);
      ctr_zero = z; ctr_prd = p;
      @(negedge clk);
      ctr_zero = 1'b0; ctr_prd = 1'b0;
   endtask

   // One counter step; expected pulse from the counter history
   task automatic step(input logic [15:0] v, input logic [15:0] k);
      logic m;
      tb_ctr = v;
      @(negedge clk);
      m = (v == k);
      chk("R1 event", {31'b0, cmp_evt}, {31'b0, m && !last_m});
      last_m = m;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [15:0] exp_act, exp_shd;
      logic        hit;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 cmp_active", {16'b0, cmp_active}, 32'h0);
      chk("R10 hr_active", {24'b0, hr_active}, 32'h0);
      chk("R10 cmp_evt", {31'b0, cmp_evt}, 32'h0);
      rd(3'd0, r); chk("R10 ctrl", r, 32'h0);
      rd(3'd1, r); chk("R10 shadow", r, 32'h0);

      // R4 sweep of all load selects against all strobe combinations
      exp_act = '0;
      exp_shd = '0;
      for (int m = 0; m < 4; m++) begin
         wr(3'd0, {29'b0, 2'(m), 1'b0});
         rd(3'd0, r); chk("R11 ctrl readback", r, {29'b0, 2'(m), 1'b0});
         for (int s = 1; s < 4; s++) begin
            exp_shd = 16'h1000 + 16'(m * 16 + s);
            wr(3'd1, {16'b0, exp_shd});
            chk("R2 active held", {16'b0, cmp_active}, {16'b0, exp_act});
            rd(3'd1, r); chk("R2 shadow read", r, {16'b0, exp_shd});
            strobe(s[0], s[1]);
            case (m)
               0: hit = s[0];
               1: hit = s[1];
               2: hit = s[0] | s[1];
               default: hit = 1'b0;
            endcase
            if (hit) exp_act = exp_shd;
            chk("R4 load select", {16'b0, cmp_active}, {16'b0, exp_act});
         end
      end

      // R3 direct mode
      wr(3'd0, 32'h1);
      rd(3'd1, r); chk("R3 read live", r, {16'b0, exp_act});
      wr(3'd1, 32'h0777);
      chk("R3 direct write", {16'b0, cmp_active}, 32'h0777);
      strobe(1'b1, 1'b1);
      chk("R3 strobes ignored", {16'b0, cmp_active}, 32'h0777);
      wr(3'd0, 32'h0);
      rd(3'd1, r); chk("R3 shadow kept", r, {16'b0, exp_shd});

      // R7 / R8 high-resolution word and its alias
      wr(3'd2, 32'hFFFF_ABCD);
      rd(3'd2, r); chk("R7 hr layout", r, 32'h0000_AB00);
      chk("R2 hr active held", {24'b0, hr_active}, 32'h0);
      wr(3'd3, 32'h0000_5C77);
      rd(3'd2, r); chk("R8 mirror write", r, 32'h0000_5C00);
      rd(3'd3, r); chk("R8 mirror reads zero", r, 32'h0);
      strobe(1'b1, 1'b0);
      chk("R8 hr loaded", {24'b0, hr_active}, 32'h5C);

      // R9 combined access
      wr(3'd4, 32'hBEEF_42FF);
      rd(3'd1, r); chk("R9 cmp part", r, 32'h0000_BEEF);
      rd(3'd2, r); chk("R9 hr part", r, 32'h0000_4200);
      rd(3'd4, r); chk("R9 combined read", r, 32'hBEEF_4200);
      chk("R9 shadowed", {16'b0, cmp_active}, {16'b0, exp_shd});
      strobe(1'b1, 1'b0);
      chk("R9 cmp loaded", {16'b0, cmp_active}, 32'hBEEF);
      chk("R9 hr loaded", {24'b0, hr_active}, 32'h42);

      // R11 unused address
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, r); chk("R11 unused reads zero", r, 32'h0);
      rd(3'd1, r); chk("R11 unused write dropped", r, 32'h0000_BEEF);

      // R6 write coinciding with load
      wr(3'd1, 32'h1111);
      @(negedge clk);
      bus_addr = 3'd1; bus_wdata = 32'h2222; bus_wen = 1'b1; ctr_zero = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0; ctr_zero = 1'b0;
      chk("R6 active takes old shadow", {16'b0, cmp_active}, 32'h1111);
      rd(3'd1, r); chk("R6 shadow takes write", r, 32'h2222);
      strobe(1'b1, 1'b0);
      chk("R6 later load", {16'b0, cmp_active}, 32'h2222);

      // R5 compare uses pre-load value
      wr(3'd1, 32'h5);
      strobe(1'b1, 1'b0);
      wr(3'd1, 32'h9);
      @(negedge clk);
      tb_ctr = 16'h9; ctr_zero = 1'b1;
      @(negedge clk);
      ctr_zero = 1'b0;
      chk("R5 no event on pre-load value", {31'b0, cmp_evt}, 32'h0);
      chk("R5 loaded", {16'b0, cmp_active}, 32'h9);
      @(negedge clk);
      chk("R1 event after load", {31'b0, cmp_evt}, 32'h1);
      @(negedge clk);
      chk("R1 stalled counter", {31'b0, cmp_evt}, 32'h0);
      tb_ctr = 16'hFFFF;

      // R1 counter sweeps in direct mode, with a stall at the match
      wr(3'd0, 32'h1);
      for (int k = 0; k < 64; k += 21) begin
         wr(3'd1, 32'(k));
         @(negedge clk);
         last_m = 1'b0;
         for (int v = 0; v < 64; v++) step(16'(v), 16'(k));
         for (int t = 0; t < 3; t++) step(16'(k), 16'(k));
         step(16'hFFFF, 16'(k));
         step(16'(k), 16'(k));
         tb_ctr = 16'hFFFF;
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule